// File: doc/BRIEF.md
# Zero-Wait-State Data Memory Port

This block sits between the data side of a processor core and a single-cycle on-chip RAM, which is built into the block. In any cycle the core may issue one request. The request carries a word address, a select, a write flag, a sequential hint, a four-bit byte-lane mask and write data. Write data travels with its own request. A read returns its word on the next clock edge. The next request can therefore be issued in the same cycle as that data, and mixed traffic flows with no stall.

A DMA engine can take over the RAM without adding logic to the core's address path. While the DMA enable is high, the RAM's address and select come from the DMA inputs through a plain combinational mux. The write flag, lane mask and write data still come from the shared request lines. Read data is held between reads, and a valid strobe marks the cycles in which it is fresh.

Top module: `tcm_dport`

## Requirements
- R1: A read request (effective select high, `req_write` = 0) in one cycle drives `rd_valid` high and puts the addressed word on `rd_data` in the next cycle.
- R2: Write data is taken in the same cycle as its write request. A read of the same word in the very next cycle returns the newly written bytes.
- R3: On a write, lane bit n of `req_lanes` enables bits 8n+7..8n of the word. 1111 writes the whole word and 0001 writes only byte 0. Bytes whose lane bit is 0 keep their old value.
- R4: A cycle with the effective select low makes no access. `rd_valid` is low in the following cycle, and the RAM contents do not change even if `req_write` is high.
- R5: `core_seq` may be high only when the core selects the address one above the address of a core request in the previous cycle. The returned data equals that of a nonsequential read of the same word.
- R6: While `dma_en` is high, the RAM address and select come from `dma_addr` and `dma_cs`, and `core_addr` and `core_cs` have no effect.
- R7: While `dma_en` is low, `dma_addr` and `dma_cs` have no effect.
- R8: In a cycle that follows no read request, `rd_valid` is low and `rd_data` keeps its previous value.
- R9: The sequence read, word write, idle, read, sequential read, byte write completes at one request per cycle with no stall.
- R10: After reset, `rd_valid` is 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_cs | input | 1 | Core request select |
| core_addr | input | AW | Core word address |
| core_seq | input | 1 | Core sequential hint |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lanes | input | 4 | Byte write-lane mask; 0000 on reads |
| req_wdata | input | 32 | Write data, presented with the request |
| dma_en | input | 1 | Route DMA address and select to the RAM |
| dma_cs | input | 1 | DMA select |
| dma_addr | input | AW | DMA word address |
| rd_data | output | 32 | Read word, one cycle after the request |
| rd_valid | output | 1 | rd_data holds a fresh read result |

## Verification
Within a single cycle, the result of the previous read appears on the output while the next request, often a write, is issued. A write to a word can also meet a read of that same word in the following cycle. The bench provokes both by running back-to-back read-after-write sequences and a long mixed-traffic run that switches between core and DMA sources. A behavioural reference array, updated on every write, judges each cycle's `rd_valid` and `rd_data`.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
    localparam int WORD_W = 32;
    localparam int LANES  = WORD_W / 8;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              valid;
    } rd_state_t;
endpackage

// File: rtl/tcm_src_mux.sv
module tcm_src_mux #(
    parameter int AW = 10
) (
    input  logic          sel_dma,
    input  logic          core_cs,
    input  logic [AW-1:0] core_addr,
    input  logic          dma_cs,
    input  logic [AW-1:0] dma_addr,
    output logic          mem_cs,
    output logic [AW-1:0] mem_addr
);
    // Pure mux: the core path sees one gate level, never a register.
    always_comb begin
        mem_cs   = sel_dma ? dma_cs   : core_cs;
        mem_addr = sel_dma ? dma_addr : core_addr;
    end
endmodule

// File: rtl/tcm_ram.sv
module tcm_ram
    import tcm_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              cs,
    input  logic              we,
    input  logic [LANES-1:0]  lanes,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rword
);
    logic [WORD_W-1:0] mem [DEPTH];

    // Word seen at the array; the read stage captures it at the edge.
    assign rword = mem[addr];

    always_ff @(posedge clk) begin
        if (cs && we) begin
            for (int n = 0; n < LANES; n++) begin
                if (lanes[n]) mem[addr][8*n +: 8] <= wdata[8*n +: 8];
            end
        end
    end
endmodule

// File: rtl/tcm_rd_stage.sv
module tcm_rd_stage
    import tcm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [WORD_W-1:0] rword,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid
);
    rd_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = rd_req;
        if (rd_req) st_d.data = rword;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data  = st_q.data;
    assign rd_valid = st_q.valid;

    // R8: output register holds whenever no read completes
    p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> $stable(rd_data));
endmodule

// File: rtl/tcm_dport.sv
module tcm_dport
    import tcm_pkg::*;
#(
    parameter  int DEPTH = 1024,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_cs,
    input  logic [AW-1:0]     core_addr,
    input  logic              core_seq,
    input  logic              req_write,
    input  logic [LANES-1:0]  req_lanes,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic              dma_en,
    input  logic              dma_cs,
    input  logic [AW-1:0]     dma_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid
);
    logic              mem_cs;
    logic [AW-1:0]     mem_addr;
    logic [WORD_W-1:0] rword;
    logic              rd_req;

    tcm_src_mux #(.AW(AW)) u_mux (
        .sel_dma   (dma_en),
        .core_cs   (core_cs),
        .core_addr (core_addr),
        .dma_cs    (dma_cs),
        .dma_addr  (dma_addr),
        .mem_cs    (mem_cs),
        .mem_addr  (mem_addr)
    );

    tcm_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
        .clk   (clk),
        .cs    (mem_cs),
        .we    (req_write),
        .lanes (req_lanes),
        .addr  (mem_addr),
        .wdata (req_wdata),
        .rword (rword)
    );

    assign rd_req = mem_cs && !req_write;

    tcm_rd_stage u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (rd_req),
        .rword    (rword),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    // R1: a core read yields valid data on the next cycle
    p_core_read_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_en && core_cs && !req_write) |=> rd_valid);

    // R4: an idle slot returns nothing
    p_idle_no_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_en ? !dma_cs : !core_cs) |=> !rd_valid);

    // R6: DMA select drives the access while enabled
    p_dma_read_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_en && dma_cs && !req_write) |=> rd_valid);

    // R7: core select alone decides while DMA is disabled
    p_core_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_en && !core_cs) |=> !rd_valid);

    // R5: sequential hint only follows a core request at address - 1
    p_seq_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (core_cs && core_seq) |-> ($past(core_cs) && core_addr == $past(core_addr) + 1'b1));

    // R3: enabled lanes take the write data, disabled lanes keep old bytes
    for (genvar n = 0; n < LANES; n++) begin : g_lane_chk
        p_lane_written_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (mem_cs && req_write && req_lanes[n]) |=>
            u_ram.mem[$past(mem_addr)][8*n +: 8] == $past(req_wdata[8*n +: 8]));
        p_lane_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (mem_cs && req_write && !req_lanes[n]) |=>
            u_ram.mem[$past(mem_addr)][8*n +: 8] == $past(rword[8*n +: 8]));
    end
endmodule

// File: tb/tcm_dport_tb.sv
module tcm_dport_tb;
    localparam int DEPTH = 1024;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          core_cs = 1'b0;
    logic [AW-1:0] core_addr = '0;
    logic          core_seq = 1'b0;
    logic          req_write = 1'b0;
    logic [3:0]    req_lanes = '0;
    logic [31:0]   req_wdata = '0;
    logic          dma_en = 1'b0;
    logic          dma_cs = 1'b0;
    logic [AW-1:0] dma_addr = '0;
    logic [31:0]   rd_data;
    logic          rd_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] ref_mem [64];
    logic [31:0] exp_data = '0;
    logic        exp_valid = 1'b0;

    tcm_dport #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .core_cs(core_cs), .core_addr(core_addr), .core_seq(core_seq),
        .req_write(req_write), .req_lanes(req_lanes), .req_wdata(req_wdata),
        .dma_en(dma_en), .dma_cs(dma_cs), .dma_addr(dma_addr),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    always #2 clk = ~clk;

    task automatic check(string tag, logic [31:0] act_d, logic act_v);
        checks++;
        if (act_v !== exp_valid) begin
            errors++;
            $display("FAIL %s: rd_valid=%b expected=%b", tag, act_v, exp_valid);
        end
        checks++;
        if (act_d !== exp_data) begin
            errors++;
            $display("FAIL %s: rd_data=%h expected=%h", tag, act_d, exp_data);
        end
    endtask

    // One request cycle: drive at negedge, update model at posedge, compare at next negedge
    task automatic step(string tag, bit cs, bit wr, bit seq, logic [3:0] ln,
                        int adr, logic [31:0] wd, bit den, bit dcs, int dadr);
        int eadr;
        bit ecs;
        core_cs = cs; req_write = wr; core_seq = seq; req_lanes = ln;
        core_addr = AW'(adr); req_wdata = wd;
        dma_en = den; dma_cs = dcs; dma_addr = AW'(dadr);
        @(posedge clk);
        ecs  = den ? dcs : cs;
        eadr = den ? dadr : adr;
        exp_valid = ecs && !wr;
        if (ecs && !wr) exp_data = ref_mem[eadr];
        if (ecs && wr)
            for (int n = 0; n < 4; n++)
                if (ln[n]) ref_mem[eadr][8*n +: 8] = wd[8*n +: 8];
        @(negedge clk);
        check(tag, rd_data, rd_valid);
    endtask

    task automatic rd(string tag, int adr);
        step(tag, 1, 0, 0, 4'b0000, adr, 32'h0, 0, 0, 0);
    endtask

    task automatic idle(string tag);
        step(tag, 0, 0, 0, 4'b0000, 0, 32'h0, 0, 0, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        int prev_addr;
        bit prev_core;
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", rd_data, rd_valid);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", rd_data, rd_valid);

        // R3: full-word writes initialise the model region
        for (int a = 0; a < 64; a++)
            step("R3", 1, 1, 0, 4'b1111, a, 32'hA5000000 ^ (a * 32'h01010101), 0, 0, 0);

        // R9: read, word write, idle, read, sequential read, byte write
        rd("R9", 5);
        step("R9", 1, 1, 0, 4'b1111, 9, 32'hDEADBEEF, 0, 0, 0);
        idle("R9");
        rd("R9", 12);
        step("R5", 1, 0, 1, 4'b0000, 13, 32'h0, 0, 0, 0);
        step("R9", 1, 1, 0, 4'b0001, 20, 32'h000000C3, 0, 0, 0);
        rd("R3", 20);
        rd("R2", 9);

        // R2: write immediately followed by read of the same word
        step("R2", 1, 1, 0, 4'b1111, 30, 32'h12345678, 0, 0, 0);
        rd("R2", 30);
        step("R3", 1, 1, 0, 4'b0010, 30, 32'hFFFFAAFF, 0, 0, 0);
        rd("R3", 30);
        step("R3", 1, 1, 0, 4'b1000, 30, 32'h99FFFFFF, 0, 0, 0);
        rd("R3", 30);

        // R8: output holds over idle and write cycles
        idle("R8");
        idle("R8");
        step("R8", 1, 1, 0, 4'b1111, 31, 32'h0BADF00D, 0, 0, 0);
        rd("R8", 31);

        // R4: write flag with select low changes nothing
        step("R4", 0, 1, 0, 4'b1111, 31, 32'hFFFFFFFF, 0, 0, 0);
        rd("R4", 31);

        // R6: DMA source overrides core address and select
        step("R6", 0, 0, 0, 4'b0000, 3, 32'h0, 1, 1, 40);
        step("R6", 0, 1, 0, 4'b1111, 3, 32'hCAFE0001, 1, 1, 41);
        rd("R6", 41);
        rd("R6", 3);
        step("R6", 1, 1, 0, 4'b1111, 42, 32'h55555555, 1, 0, 0);
        rd("R6", 42);
        step("R6", 1, 0, 0, 4'b0000, 42, 32'h0, 1, 0, 0);

        // R7: DMA inputs ignored while disabled
        step("R7", 0, 1, 0, 4'b1111, 0, 32'h77777777, 0, 1, 43);
        rd("R7", 43);
        step("R7", 1, 0, 0, 4'b0000, 44, 32'h0, 0, 1, 45);

        // R5: sequential runs and mixed traffic from both sources
        prev_addr = 0;
        prev_core = 1'b0;
        for (int i = 0; i < 400; i++) begin
            bit cs, wr, seq, den, dcs;
            int adr, dadr;
            logic [3:0] ln;
            cs   = ($urandom % 5) != 0;
            wr   = $urandom % 2;
            den  = ($urandom % 4) == 0;
            dcs  = $urandom % 2;
            dadr = $urandom % 64;
            ln   = wr ? 4'($urandom) : 4'b0000;
            seq  = 1'b0;
            adr  = $urandom % 64;
            if (cs && prev_core && prev_addr < 63 && ($urandom % 2)) begin
                seq = 1'b1;
                adr = prev_addr + 1;
            end
            step(seq ? "R5" : "R9", cs, wr, seq, ln, adr, $urandom, den, dcs, dadr);
            prev_core = cs;
            prev_addr = adr;
        end
        idle("R8");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule